// File: doc/BRIEF.md
# Receive Channel Dispatcher

This block takes a stream of complete, already checked receive frames, one byte per cycle, and steers each frame to one or more of up to eight channels. Each channel owns a 48-bit station address and two receive containers that it fills alternately. The dispatcher reads the destination address from the first six bytes of the frame. It compares that address against every enabled channel's address and then replays the whole frame, header included, as write strobes to the chosen channels. Each strobe carries the index of the container being filled.

A frame whose destination is all ones is a broadcast. When broadcast is allowed, it is copied to every enabled channel that has room. A frame that reaches no channel is dropped as a destination failure. A frame whose target channel has no free container is dropped for that channel as a channel-full event. Four counters record accepted frames, accepted broadcasts, destination failures and channel-full events. Software returns a filled container through a per-channel release strobe.

The input is expected to be gap-free inside a frame and at least six bytes long. This holds for frames that have already passed length and checksum filtering.

Top module: `rx_chan_dispatch`

## Requirements
- R1: After reset there are no write strobes, all four counters read zero, and every channel's first delivery goes to container 0.
- R2: While `glb_enable` is 0 when a frame's sixth byte arrives, that frame produces no write strobe and leaves every counter unchanged.
- R3: A frame is delivered to an enabled channel only when its destination address matches that channel's address in all 48 bits. The first received byte is compared with address bits 47:40. The frame is delivered in full: `wr_data` repeats each input byte 7 clock edges after the cycle in which it was presented. `wr_first` and `wr_last` mark the frame's ends, and `wr_en` holds the same value for the whole frame.
- R4: A channel whose bit in `ch_enable` is 0 receives nothing, even when the address matches. If no other channel is targeted, the frame counts as a destination failure.
- R5: A frame that matches no enabled channel writes nothing and increments `cnt_dst_fail` by exactly one.
- R6: With `bcast_enable` at 1, an all-ones destination is written to every enabled channel that has a free container, and `cnt_bcast` increments by one. If no channel is enabled, `cnt_dst_fail` also increments.
- R7: With `bcast_enable` at 0, an all-ones destination is written nowhere, increments `cnt_dst_fail` and leaves `cnt_bcast` unchanged.
- R8: Each channel fills its containers in the order 0, 1, 0, 1. `wr_sel[i]` is 0 for container 0 and 1 for container 1.
- R9: A targeted channel whose next container in the 0, 1 order is still filled receives nothing. `cnt_ch_full` grows by the number of such channels for that frame, and `cnt_dst_fail` is unchanged.
- R10: A pulse on `rel_c0[i]` or `rel_c1[i]` frees container 0 or 1 of channel i, so the next frame for that channel is accepted again.
- R11: `cnt_rx` increments by one for every frame whose header completes while `glb_enable` is 1, whatever its outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte valid |
| in_first | input | 1 | First byte of a frame |
| in_last | input | 1 | Last byte of a frame |
| in_data | input | 8 | Frame byte |
| ch_enable | input | NUM_CH | Per-channel delivery enable |
| glb_enable | input | 1 | Global dispatch enable |
| bcast_enable | input | 1 | Accept all-ones destination |
| ch_addr | input | NUM_CH*48 | Channel i address at bits [48*i +: 48] |
| rel_c0 | input | NUM_CH | Release container 0 of channel i |
| rel_c1 | input | NUM_CH | Release container 1 of channel i |
| wr_en | output | NUM_CH | Per-channel write strobe |
| wr_sel | output | NUM_CH | Container index being written, per channel |
| wr_data | output | 8 | Byte written |
| wr_first | output | 1 | First byte of the written frame |
| wr_last | output | 1 | Last byte of the written frame |
| cnt_rx | output | CNT_W | Accepted frame count |
| cnt_bcast | output | CNT_W | Accepted broadcast count |
| cnt_dst_fail | output | CNT_W | Destination failure count |
| cnt_ch_full | output | CNT_W | Channel-full drop count |

## Verification
The assertions watch the counters and strobes on every cycle. They check that nothing is counted while dispatch is off, that broadcast, destination-failure and channel-full steps only come with an accepted frame, and that a failure and a full drop never step together. They also check that the write mask stays fixed across a frame. Address matching, the 0, 1 container order, the effect of releases, the exact byte latency and the reset of the container pointers need a known sequence of frames. Only the bench's scenarios can show those.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
  localparam int BYTE_W = 8;

  typedef struct packed {
    logic              vld;
    logic              sop;
    logic              eop;
    logic [BYTE_W-1:0] dat;
  } beat_t;
endpackage

// File: rtl/rxd_hdr_delay.sv
module rxd_hdr_delay
  import rxd_pkg::*;
#(
  parameter int HDR_BYTES = 6
) (
  input  logic                     clk,
  input  logic                     rst,
  input  beat_t                    in_beat,
  output beat_t                    out_beat,
  output logic                     hdr_done,
  output logic [HDR_BYTES*8-1:0]   hdr_addr
);
  localparam int CW = $clog2(HDR_BYTES + 1);

  beat_t         stage_q [HDR_BYTES];
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < HDR_BYTES; k++) stage_q[k] <= '0;
      cnt_q <= '0;
    end else begin
      stage_q[0] <= in_beat;
      for (int k = 1; k < HDR_BYTES; k++) stage_q[k] <= stage_q[k-1];
      if (in_beat.vld) begin
        if (in_beat.sop) cnt_q <= CW'(1);
        else if (cnt_q != '0 && cnt_q < CW'(HDR_BYTES)) cnt_q <= cnt_q + CW'(1);
      end
    end
  end

  // Last header byte is on the input; earlier ones sit in the stages.
  assign hdr_done = in_beat.vld && !in_beat.sop && (cnt_q == CW'(HDR_BYTES - 1));
  assign hdr_addr[BYTE_W-1:0] = in_beat.dat;

  for (genvar j = 1; j < HDR_BYTES; j++) begin : g_addr
    assign hdr_addr[j*BYTE_W +: BYTE_W] = stage_q[j-1].dat;
  end

  assign out_beat = stage_q[HDR_BYTES-1];
endmodule

// File: rtl/rxd_chan_bank.sv
module rxd_chan_bank #(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] take,
  input  logic [NUM_CH-1:0] rel_c0,
  input  logic [NUM_CH-1:0] rel_c1,
  output logic [NUM_CH-1:0] free,
  output logic [NUM_CH-1:0] ptr
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic [1:0] busy_q;
    logic       ptr_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        busy_q <= 2'b00;
        ptr_q  <= 1'b0;
      end else begin
        busy_q <= (busy_q & ~{rel_c1[i], rel_c0[i]})
                | (take[i] ? (ptr_q ? 2'b10 : 2'b01) : 2'b00);
        if (take[i]) ptr_q <= ~ptr_q;
      end
    end

    assign free[i] = ~busy_q[ptr_q];
    assign ptr[i]  = ptr_q;
  end
endmodule

// File: rtl/rxd_stats.sv
module rxd_stats #(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 16,
  localparam int FW    = $clog2(NUM_CH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc_rx,
  input  logic             inc_bc,
  input  logic             inc_dst,
  input  logic [FW-1:0]    full_add,
  output logic [CNT_W-1:0] cnt_rx,
  output logic [CNT_W-1:0] cnt_bcast,
  output logic [CNT_W-1:0] cnt_dst_fail,
  output logic [CNT_W-1:0] cnt_ch_full
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_rx       <= '0;
      cnt_bcast    <= '0;
      cnt_dst_fail <= '0;
      cnt_ch_full  <= '0;
    end else begin
      if (inc_rx)  cnt_rx       <= cnt_rx + CNT_W'(1);
      if (inc_bc)  cnt_bcast    <= cnt_bcast + CNT_W'(1);
      if (inc_dst) cnt_dst_fail <= cnt_dst_fail + CNT_W'(1);
      cnt_ch_full <= cnt_ch_full + CNT_W'(full_add);
    end
  end
endmodule

// File: rtl/rx_chan_dispatch.sv
module rx_chan_dispatch
  import rxd_pkg::*;
#(
  parameter int NUM_CH    = 4,
  parameter int CNT_W     = 16,
  parameter int HDR_BYTES = 6
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       in_valid,
  input  logic                       in_first,
  input  logic                       in_last,
  input  logic [7:0]                 in_data,
  input  logic [NUM_CH-1:0]          ch_enable,
  input  logic                       glb_enable,
  input  logic                       bcast_enable,
  input  logic [NUM_CH*HDR_BYTES*8-1:0] ch_addr,
  input  logic [NUM_CH-1:0]          rel_c0,
  input  logic [NUM_CH-1:0]          rel_c1,
  output logic [NUM_CH-1:0]          wr_en,
  output logic [NUM_CH-1:0]          wr_sel,
  output logic [7:0]                 wr_data,
  output logic                       wr_first,
  output logic                       wr_last,
  output logic [CNT_W-1:0]           cnt_rx,
  output logic [CNT_W-1:0]           cnt_bcast,
  output logic [CNT_W-1:0]           cnt_dst_fail,
  output logic [CNT_W-1:0]           cnt_ch_full
);
  localparam int ADDR_W = HDR_BYTES * 8;
  localparam int FW     = $clog2(NUM_CH + 1);

  if (NUM_CH < 1 || NUM_CH > 8) begin : g_bad_cfg
    $error("NUM_CH must lie between 1 and 8");
  end

  beat_t              in_beat, dly_beat;
  logic               hdr_done;
  logic [ADDR_W-1:0]  hdr_addr;
  logic [NUM_CH-1:0]  hit, target, deliver, blocked, take;
  logic [NUM_CH-1:0]  chan_free, chan_ptr;
  logic [NUM_CH-1:0]  route_q, sel_q;
  logic               is_bcast, decide;
  logic [FW-1:0]      full_add;

  assign in_beat = '{vld: in_valid, sop: in_first, eop: in_last, dat: in_data};

  rxd_hdr_delay #(.HDR_BYTES(HDR_BYTES)) u_hdr (
    .clk     (clk),
    .rst     (rst),
    .in_beat (in_beat),
    .out_beat(dly_beat),
    .hdr_done(hdr_done),
    .hdr_addr(hdr_addr)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_match
    assign hit[i] = (ch_addr[i*ADDR_W +: ADDR_W] == hdr_addr);
  end

  always_comb begin
    is_bcast = &hdr_addr;
    target   = is_bcast ? (bcast_enable ? ch_enable : '0) : (ch_enable & hit);
    deliver  = target & chan_free;
    blocked  = target & ~chan_free;
    decide   = hdr_done & glb_enable;
    take     = decide ? deliver : '0;
    full_add = decide ? FW'($countones(blocked)) : '0;
  end

  rxd_chan_bank #(.NUM_CH(NUM_CH)) u_bank (
    .clk   (clk),
    .rst   (rst),
    .take  (take),
    .rel_c0(rel_c0),
    .rel_c1(rel_c1),
    .free  (chan_free),
    .ptr   (chan_ptr)
  );

  rxd_stats #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_stats (
    .clk         (clk),
    .rst         (rst),
    .inc_rx      (decide),
    .inc_bc      (decide & is_bcast & bcast_enable),
    .inc_dst     (decide & (target == '0)),
    .full_add    (full_add),
    .cnt_rx      (cnt_rx),
    .cnt_bcast   (cnt_bcast),
    .cnt_dst_fail(cnt_dst_fail),
    .cnt_ch_full (cnt_ch_full)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      route_q  <= '0;
      sel_q    <= '0;
      wr_en    <= '0;
      wr_sel   <= '0;
      wr_data  <= '0;
      wr_first <= 1'b0;
      wr_last  <= 1'b0;
    end else begin
      if (hdr_done) begin
        route_q <= take;
        sel_q   <= chan_ptr;
      end
      wr_en    <= dly_beat.vld ? route_q : '0;
      wr_sel   <= sel_q;
      wr_data  <= dly_beat.dat;
      wr_first <= dly_beat.vld & dly_beat.sop;
      wr_last  <= dly_beat.vld & dly_beat.eop;
    end
  end
endmodule

// File: rtl/rx_chan_dispatch_chk.sv
module rx_chan_dispatch_chk #(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              glb_enable,
  input logic [NUM_CH-1:0] wr_en,
  input logic              wr_last,
  input logic [CNT_W-1:0]  cnt_rx,
  input logic [CNT_W-1:0]  cnt_bcast,
  input logic [CNT_W-1:0]  cnt_dst_fail,
  input logic [CNT_W-1:0]  cnt_ch_full
);
  assert_ignore_when_off_R2: assert property (@(posedge clk) disable iff (rst)
    !$past(glb_enable) |-> (cnt_rx == $past(cnt_rx)));

  assert_bcast_needs_rx_R6: assert property (@(posedge clk) disable iff (rst)
    (cnt_bcast != $past(cnt_bcast)) |-> (cnt_rx != $past(cnt_rx)));

  assert_dst_single_step_R5: assert property (@(posedge clk) disable iff (rst)
    (CNT_W'(cnt_dst_fail - $past(cnt_dst_fail)) <= CNT_W'(1)));

  assert_dst_needs_rx_R11: assert property (@(posedge clk) disable iff (rst)
    (cnt_dst_fail != $past(cnt_dst_fail)) |-> (cnt_rx != $past(cnt_rx)));

  assert_full_bounded_R9: assert property (@(posedge clk) disable iff (rst)
    (CNT_W'(cnt_ch_full - $past(cnt_ch_full)) <= CNT_W'(NUM_CH)));

  assert_full_excludes_dst_R9: assert property (@(posedge clk) disable iff (rst)
    (cnt_dst_fail != $past(cnt_dst_fail)) |-> (cnt_ch_full == $past(cnt_ch_full)));

  assert_steady_mask_R3: assert property (@(posedge clk) disable iff (rst)
    ((|wr_en) && !wr_last) |=> (wr_en == $past(wr_en)));
endmodule

bind rx_chan_dispatch rx_chan_dispatch_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .glb_enable  (glb_enable),
  .wr_en       (wr_en),
  .wr_last     (wr_last),
  .cnt_rx      (cnt_rx),
  .cnt_bcast   (cnt_bcast),
  .cnt_dst_fail(cnt_dst_fail),
  .cnt_ch_full (cnt_ch_full)
);

// File: tb/rx_chan_dispatch_tb_top.sv
`timescale 1ns/1ps
module rx_chan_dispatch_tb_top;
  localparam int NC    = 4;
  localparam int CW    = 16;
  localparam int LEN   = 12;
  localparam int NV    = 13;
  localparam logic [47:0] BASE = 48'h0A1B2C3D4E50;

  typedef struct packed {
    logic [2:0] tgt;   // 0..3 channel, 4 broadcast, 5 unknown
    logic [3:0] en;
    logic       bc;
    logic       ge;
    logic [3:0] r0;
    logic [3:0] r1;
    logic [3:0] xmask;
    logic [3:0] xsel;
    logic [1:0] drx;
    logic [1:0] dbc;
    logic [1:0] ddst;
    logic [2:0] dfull;
  } vec_t;

  localparam vec_t VEC [NV] = '{
    '{3'd0, 4'hF, 1'b0, 1'b1, 4'h0, 4'h0, 4'h1, 4'h0, 2'd1, 2'd0, 2'd0, 3'd0},
    '{3'd0, 4'hF, 1'b0, 1'b1, 4'h0, 4'h0, 4'h1, 4'h1, 2'd1, 2'd0, 2'd0, 3'd0},
    '{3'd0, 4'hF, 1'b0, 1'b1, 4'h0, 4'h0, 4'h0, 4'h0, 2'd1, 2'd0, 2'd0, 3'd1},
    '{3'd0, 4'hF, 1'b0, 1'b1, 4'h1, 4'h0, 4'h1, 4'h0, 2'd1, 2'd0, 2'd0, 3'd0},
    '{3'd2, 4'hB, 1'b0, 1'b1, 4'h0, 4'h0, 4'h0, 4'h0, 2'd1, 2'd0, 2'd1, 3'd0},
    '{3'd5, 4'hF, 1'b0, 1'b1, 4'h0, 4'h0, 4'h0, 4'h0, 2'd1, 2'd0, 2'd1, 3'd0},
    '{3'd4, 4'hF, 1'b0, 1'b1, 4'h0, 4'h0, 4'h0, 4'h0, 2'd1, 2'd0, 2'd1, 3'd0},
    '{3'd4, 4'h7, 1'b1, 1'b1, 4'h0, 4'h0, 4'h6, 4'h0, 2'd1, 2'd1, 2'd0, 3'd1},
    '{3'd1, 4'hF, 1'b0, 1'b0, 4'h0, 4'h0, 4'h0, 4'h0, 2'd0, 2'd0, 2'd0, 3'd0},
    '{3'd1, 4'hF, 1'b0, 1'b1, 4'h0, 4'h0, 4'h2, 4'h2, 2'd1, 2'd0, 2'd0, 3'd0},
    '{3'd0, 4'hF, 1'b0, 1'b1, 4'h0, 4'h1, 4'h1, 4'h1, 2'd1, 2'd0, 2'd0, 3'd0},
    '{3'd3, 4'h8, 1'b0, 1'b1, 4'h0, 4'h0, 4'h8, 4'h0, 2'd1, 2'd0, 2'd0, 3'd0},
    '{3'd4, 4'h0, 1'b1, 1'b1, 4'h0, 4'h0, 4'h0, 4'h0, 2'd1, 2'd1, 2'd1, 3'd0}
  };

  string vec_tag [NV] = '{"R3", "R8", "R9", "R10", "R4", "R5", "R7",
                          "R6", "R2", "R8", "R10", "R3", "R6"};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_first = 1'b0, in_last = 1'b0;
  logic [7:0] in_data = '0;
  logic [NC-1:0] ch_enable = '0, rel_c0 = '0, rel_c1 = '0;
  logic glb_enable = 1'b0, bcast_enable = 1'b0;
  logic [NC*48-1:0] ch_addr;
  logic [NC-1:0] wr_en, wr_sel;
  logic [7:0] wr_data;
  logic wr_first, wr_last;
  logic [CW-1:0] cnt_rx, cnt_bcast, cnt_dst_fail, cnt_ch_full;

  int total = 0, bad = 0, cyc = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  for (genvar i = 0; i < NC; i++) begin : g_addr
    assign ch_addr[i*48 +: 48] = BASE + 48'(i);
  end

  rx_chan_dispatch #(.NUM_CH(NC), .CNT_W(CW), .HDR_BYTES(6)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_first(in_first),
    .in_last(in_last), .in_data(in_data), .ch_enable(ch_enable),
    .glb_enable(glb_enable), .bcast_enable(bcast_enable), .ch_addr(ch_addr),
    .rel_c0(rel_c0), .rel_c1(rel_c1), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .wr_first(wr_first), .wr_last(wr_last),
    .cnt_rx(cnt_rx), .cnt_bcast(cnt_bcast), .cnt_dst_fail(cnt_dst_fail),
    .cnt_ch_full(cnt_ch_full)
  );

  // Output monitor
  logic [NC-1:0] obs_mask, obs_sel;
  int obs_bytes, obs_first_cyc;
  logic [7:0] obs_first_dat;
  always @(negedge clk) begin
    if (|wr_en) begin
      obs_mask  <= obs_mask | wr_en;
      obs_sel   <= obs_sel | (wr_sel & wr_en);
      obs_bytes <= obs_bytes + 1;
      if (wr_first) begin
        obs_first_cyc <= cyc;
        obs_first_dat <= wr_data;
      end
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send_pkt(input logic [47:0] dst);
    for (int b = 0; b < LEN; b++) begin
      in_valid = 1'b1;
      in_first = (b == 0);
      in_last  = (b == LEN - 1);
      in_data  = (b < 6) ? dst[47 - 8*b -: 8] : 8'(8'h30 + b);
      @(negedge clk);
    end
    in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0;
  endtask

  task automatic clear_obs();
    obs_mask = '0; obs_sel = '0; obs_bytes = 0; obs_first_cyc = 0; obs_first_dat = '0;
  endtask

  function automatic logic [47:0] dst_of(input logic [2:0] t);
    if (t < 3'd4) return BASE + 48'(t);
    if (t == 3'd4) return '1;
    return BASE + 48'h0F;
  endfunction

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog all-R actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [CW-1:0] s_rx, s_bc, s_dst, s_full;
    int c0;
    clear_obs();
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 wr_en after reset", 64'(wr_en), 64'h0);
    chk("R1 cnt_rx after reset", 64'(cnt_rx), 64'h0);
    chk("R1 cnt_bcast after reset", 64'(cnt_bcast), 64'h0);
    chk("R1 cnt_dst_fail after reset", 64'(cnt_dst_fail), 64'h0);
    chk("R1 cnt_ch_full after reset", 64'(cnt_ch_full), 64'h0);

    for (int v = 0; v < NV; v++) begin
      ch_enable = VEC[v].en; bcast_enable = VEC[v].bc; glb_enable = VEC[v].ge;
      if ((VEC[v].r0 | VEC[v].r1) != '0) begin
        rel_c0 = VEC[v].r0; rel_c1 = VEC[v].r1;
        @(negedge clk);
        rel_c0 = '0; rel_c1 = '0;
      end
      s_rx = cnt_rx; s_bc = cnt_bcast; s_dst = cnt_dst_fail; s_full = cnt_ch_full;
      clear_obs();
      c0 = cyc;
      send_pkt(dst_of(VEC[v].tgt));
      repeat (10) @(negedge clk);
      chk({vec_tag[v], " write mask"}, 64'(obs_mask), 64'(VEC[v].xmask));
      chk({vec_tag[v], " R8 container select"}, 64'(obs_sel), 64'(VEC[v].xsel));
      chk({vec_tag[v], " byte count"}, 64'(obs_bytes), (VEC[v].xmask != 0) ? 64'(LEN) : 64'h0);
      chk({vec_tag[v], " R11 cnt_rx delta"}, 64'(CW'(cnt_rx - s_rx)), 64'(VEC[v].drx));
      chk({vec_tag[v], " cnt_bcast delta"}, 64'(CW'(cnt_bcast - s_bc)), 64'(VEC[v].dbc));
      chk({vec_tag[v], " cnt_dst_fail delta"}, 64'(CW'(cnt_dst_fail - s_dst)), 64'(VEC[v].ddst));
      chk({vec_tag[v], " R9 cnt_ch_full delta"}, 64'(CW'(cnt_ch_full - s_full)), 64'(VEC[v].dfull));
      if (VEC[v].xmask != 0) begin
        chk({vec_tag[v], " R3 first byte"}, 64'(obs_first_dat), 64'(dst_of(VEC[v].tgt) >> 40));
        chk({vec_tag[v], " R3 latency"}, 64'(obs_first_cyc - c0), 64'd7);
      end
    end

    // R3: one differing low bit must not match
    ch_enable = 4'hF; glb_enable = 1'b1; bcast_enable = 1'b0;
    clear_obs();
    send_pkt(BASE ^ 48'h000000000100);
    repeat (10) @(negedge clk);
    chk("R3 near-miss address mask", 64'(obs_mask), 64'h0);

    // R1: mid-run reset clears counters and container pointers
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 cnt_rx after second reset", 64'(cnt_rx), 64'h0);
    chk("R1 cnt_ch_full after second reset", 64'(cnt_ch_full), 64'h0);
    clear_obs();
    send_pkt(BASE + 48'd1);
    repeat (10) @(negedge clk);
    chk("R1 delivery after reset mask", 64'(obs_mask), 64'h2);
    chk("R1 delivery after reset container", 64'(obs_sel), 64'h0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule